// File: doc/BRIEF.md
# Slow-Clock System Timer with Absolute Alarm

This block is a system timer peripheral. It keeps time from a low-frequency reference clock (nominally 32768 Hz) and is read and written over a simple register bus in the fast system clock domain. The timer has four parts:

- a free-running real-time counter behind a programmable prescaler;
- an alarm that compares against an absolute counter value;
- a periodic interval timer that reloads itself;
- a reduced watchdog that only reports when its down-counter runs out.

Each source latches a bit in a status register. Reading the status register clears those bits. Enable and disable registers select which status bits drive the single interrupt output.

The reference clock is never used as a clock. The block samples it in the bus domain through a synchronizer and turns each rising edge into a one-cycle step pulse. All counters therefore live in the bus clock domain. Every read of the counter returns a value the counter really held, and software needs no read-twice loop.

The alarm fires on the increment that brings the counter to the programmed value. If the alarm is written with the count that is already current, it fires only after the counter wraps all the way round.

Top module: `st_timer`

## Requirements
- R1: The counter is CNT_W bits wide (default 20). It increases by one per increment and wraps from all ones to zero. It reads at offset 0x1C, and writes to that offset are ignored.
- R2: The prescaler register at 0x04 holds 16 bits and resets to 0x8000; the value 0 means 65536. The counter increments once every N rising edges of slow_clk. Writing the prescaler clears the counter and the prescale phase.
- R3: The alarm register at 0x18 holds an absolute count. Status bit 3 sets on the increment that brings the counter to that value. An alarm equal to the current count fires only after a full wrap.
- R4: Writing the alarm register replaces any pending target, and the previous target no longer fires.
- R5: The periodic register at 0x00 holds 16 bits and resets to 0, which means 65536. Status bit 0 sets once every P rising edges of slow_clk, with automatic reload. Writing the register restarts the period.
- R6: Status bit 2 sets on every counter increment.
- R7: Writing N≠0 to offset 0x20 arms a 16-bit down-counter that decrements on every slow_clk rising edge. Status bit 1 sets when it reaches zero, and the counter then stops. Writing 0 disarms it.
- R8: A read of the status register at 0x08 returns the latched bits and clears them. An event in the same cycle as the read stays latched.
- R9: A write to 0x0C sets the mask bits written as 1, and a write to 0x10 clears them. Bits written as 0 are unchanged. The mask reads at 0x14 and resets to 0.
- R10: irq is high while any status bit is set together with its mask bit. It drops once the status is read or the mask bit is cleared.
- R11: Read data appears on bus_rdata in the cycle after bus_rd and holds until the next read. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_clk | input | 1 | Low-frequency reference, sampled asynchronously |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The assertions check the following on every cycle:

- the counter only steps by one or returns to zero;
- a prescaler write leaves the counter at zero;
- an alarm event leaves the counter equal to the alarm value;
- an increment always latches its status bit;
- a status read with no coincident event leaves both status and irq clear;
- an enable write sets its bits;
- read data holds between reads.

Other behaviours need the bench's scenarios and its cycle-accurate model:

- the full-wrap delay of an alarm written with the current count;
- replacement of a pending alarm;
- the periodic reload spacing;
- the watchdog stopping after it expires;
- status reads that coincide with events.

// File: rtl/st_timer_pkg.sv
// Shared constants for the slow-clock system timer: status bit
// positions and register byte offsets decoded on the bus.
package st_timer_pkg;
    localparam int STAT_W    = 4;
    // Status bit positions (software decodes these).
    localparam int BIT_PIT   = 0;
    localparam int BIT_WDOVF = 1;
    localparam int BIT_RTINC = 2;
    localparam int BIT_ALARM = 3;
    // Register byte offsets.
    localparam logic [5:0] OFS_PERIOD = 6'h00;
    localparam logic [5:0] OFS_PRESC  = 6'h04;
    localparam logic [5:0] OFS_STATUS = 6'h08;
    localparam logic [5:0] OFS_IEN    = 6'h0C;
    localparam logic [5:0] OFS_IDIS   = 6'h10;
    localparam logic [5:0] OFS_MASK   = 6'h14;
    localparam logic [5:0] OFS_ALARM  = 6'h18;
    localparam logic [5:0] OFS_COUNT  = 6'h1C;
    localparam logic [5:0] OFS_WDOG   = 6'h20;
endpackage

// File: rtl/st_edge_sync.sv
// Samples an asynchronous slow clock into the bus domain and emits a
// one-cycle pulse per rising edge.
// Assumes: the slow clock stays high and low for at least two bus cycles each.
module st_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh;

    // Shift the sampled level through the synchronizer chain plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], async_in};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/st_divider.sv
// Counts step pulses and fires on every PERIOD-th one, then reloads.
// A period of 0 stands for 2**W. A restart clears the phase and
// suppresses the fire in that cycle.
module st_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         step,
    input  logic [W-1:0] period,
    output logic         fire
);
    localparam int PW = W + 1;

    logic [W-1:0]  phase;
    logic [PW-1:0] period_eff;

    assign period_eff = (period == '0) ? (PW'(1) << W) : PW'(period);
    assign fire       = step & ~restart & ((PW'(phase) + PW'(1)) == period_eff);

    // Advance the phase on each step and wrap it when the period completes.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (restart) phase <= '0;
        else if (step)    phase <= fire ? '0 : phase + 1'b1;
    end
endmodule

// File: rtl/st_watchdog.sv
// Reduced watchdog: a down-counter loaded by a write. It decrements on each
// step and pulses once when it reaches zero, then stays idle until reloaded.
// A load of zero disarms it.
module st_watchdog #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic         expire
);
    logic [W-1:0] remain;
    logic         armed;

    assign expire = step & ~load & armed & (remain == W'(1));

    // Load, count down while armed, and disarm on reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            armed  <= 1'b0;
        end else if (load) begin
            remain <= load_val;
            armed  <= |load_val;
        end else if (step && armed) begin
            remain <= remain - 1'b1;
            if (remain == W'(1)) armed <= 1'b0;
        end
    end
endmodule

// File: rtl/st_timer.sv
// Slow-clock system timer, top level. Holds the register file, the
// real-time counter, the alarm compare, status latching and the interrupt mask.
// Assumes: single-cycle bus strobes, and ADDR_W covers the offsets in st_timer_pkg.
module st_timer
    import st_timer_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int PRE_W       = 16,
    parameter int PIT_W       = 16,
    parameter int WDT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PRE_RESET   = 32768,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [PRE_W-1:0] PRESC_INIT = PRE_W'(PRE_RESET);

    logic              slow_tick;
    logic              wr_period, wr_presc, wr_ien, wr_idis, wr_alarm, wr_wdog;
    logic              rd_status;
    logic [PRE_W-1:0]  presc_q;
    logic [PIT_W-1:0]  period_q;
    logic [CNT_W-1:0]  alarm_q, cnt_q, cnt_next;
    logic [STAT_W-1:0] mask_q, status_q, evt;
    logic [DATA_W-1:0] rd_val;
    logic              inc_fire, pit_fire, wd_fire, alarm_fire;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // Register decode.
    assign wr_period = bus_wr && (bus_addr == ADDR_W'(OFS_PERIOD));
    assign wr_presc  = bus_wr && (bus_addr == ADDR_W'(OFS_PRESC));
    assign wr_ien    = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
    assign wr_idis   = bus_wr && (bus_addr == ADDR_W'(OFS_IDIS));
    assign wr_alarm  = bus_wr && (bus_addr == ADDR_W'(OFS_ALARM));
    assign wr_wdog   = bus_wr && (bus_addr == ADDR_W'(OFS_WDOG));
    assign rd_status = bus_rd && (bus_addr == ADDR_W'(OFS_STATUS));

    st_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (slow_clk),
        .rise     (slow_tick)
    );

    st_divider #(.W(PRE_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_presc),
        .step    (slow_tick),
        .period  (presc_q),
        .fire    (inc_fire)
    );

    st_divider #(.W(PIT_W)) u_pit (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_period),
        .step    (slow_tick),
        .period  (period_q),
        .fire    (pit_fire)
    );

    st_watchdog #(.W(WDT_W)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_wdog),
        .load_val (bus_wdata[WDT_W-1:0]),
        .step     (slow_tick),
        .expire   (wd_fire)
    );

    assign cnt_next   = cnt_q + 1'b1;
    assign alarm_fire = inc_fire && (cnt_next == alarm_q);

    // Gather this cycle's events into status bit order.
    always_comb begin
        evt            = '0;
        evt[BIT_PIT]   = pit_fire;
        evt[BIT_WDOVF] = wd_fire;
        evt[BIT_RTINC] = inc_fire;
        evt[BIT_ALARM] = alarm_fire;
    end

    // Prescaler and periodic configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q  <= PRESC_INIT;
            period_q <= '0;
        end else begin
            if (wr_presc)  presc_q  <= bus_wdata[PRE_W-1:0];
            if (wr_period) period_q <= bus_wdata[PIT_W-1:0];
        end
    end

    // Absolute alarm target; each write replaces the previous target.
    always_ff @(posedge clk) begin
        if (!rst_n)        alarm_q <= '0;
        else if (wr_alarm) alarm_q <= bus_wdata[CNT_W-1:0];
    end

    // Real-time counter: cleared by a prescaler write, otherwise stepped by the prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (wr_presc) cnt_q <= '0;
        else if (inc_fire) cnt_q <= cnt_next;
    end

    // Interrupt mask: set-ones and clear-ones writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_ien)  mask_q <= mask_q | bus_wdata[STAT_W-1:0];
        else if (wr_idis) mask_q <= mask_q & ~bus_wdata[STAT_W-1:0];
    end

    // Status: a read clears it, and new events are merged in after the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (rd_status ? '0 : status_q) | evt;
    end

    // Read multiplexer over the current register values.
    always_comb begin
        rd_val = '0;
        case (bus_addr)
            ADDR_W'(OFS_PERIOD): rd_val = DATA_W'(period_q);
            ADDR_W'(OFS_PRESC):  rd_val = DATA_W'(presc_q);
            ADDR_W'(OFS_STATUS): rd_val = DATA_W'(status_q);
            ADDR_W'(OFS_MASK):   rd_val = DATA_W'(mask_q);
            ADDR_W'(OFS_ALARM):  rd_val = DATA_W'(alarm_q);
            ADDR_W'(OFS_COUNT):  rd_val = DATA_W'(cnt_q);
            default:             rd_val = '0;
        endcase
    end

    // Capture read data one cycle after the strobe and hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    assign irq = |(status_q & mask_q);
endmodule

// File: rtl/st_timer_chk.sv
// Property checker for st_timer, bound to every instance of the top module.
module st_timer_chk
    import st_timer_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  alarm_q,
    input logic [STAT_W-1:0] status_q,
    input logic [STAT_W-1:0] mask_q,
    input logic [STAT_W-1:0] evt,
    input logic              wr_presc
);
    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) || (cnt_q == '0));

    // R2
    presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_presc |=> (cnt_q == '0));

    // R3
    alarm_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[BIT_ALARM] |=> (cnt_q == $past(alarm_q)));

    // R6
    rtinc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[BIT_RTINC] |=> status_q[BIT_RTINC]);

    // R8
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFS_STATUS) && evt == '0) |=> (status_q == '0));

    // R9
    mask_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_IEN)) |=>
        ((mask_q & $past(bus_wdata[STAT_W-1:0])) == $past(bus_wdata[STAT_W-1:0])));

    // R10
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFS_STATUS) && evt == '0) |=> !irq);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind st_timer st_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .cnt_q     (cnt_q),
    .alarm_q   (alarm_q),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .evt       (evt),
    .wr_presc  (wr_presc)
);

// File: tb/st_timer_bench.sv
// Bench for st_timer: a behavioural per-cycle model compared on every clock,
// plus directed scenarios. The counter width is reduced so a full wrap fits.
module st_timer_bench;
    localparam int CW   = 10;
    localparam int CMOD = 1 << CW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0, errors = 0, cyc = 0, sc = 0;
    bit srun = 0, ready = 0;
    string cur_tag = "R11";

    always #5 clk = ~clk;

    st_timer #(.CNT_W(CW)) u_st_timer (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Reference model state.
    int m1, m2, m3, m_presc, m_pph, m_cnt, m_per, m_pph2, m_wd, m_warm;
    int m_alm, m_st, m_mask, m_rdata;

    always @(posedge clk) begin : model
        int tick, inc, pitf, wdf, alf, ev, peff, qeff, a, d;
        if (!rst_n) begin
            m1 = 0; m2 = 0; m3 = 0; m_presc = 32768; m_pph = 0; m_cnt = 0;
            m_per = 0; m_pph2 = 0; m_wd = 0; m_warm = 0; m_alm = 0;
            m_st = 0; m_mask = 0; m_rdata = 0;
            ready = 1;
        end else begin
            a = int'(bus_addr);
            d = int'(bus_wdata);
            tick = (m2 == 1 && m3 == 0) ? 1 : 0;
            peff = (m_presc == 0) ? 65536 : m_presc;
            qeff = (m_per == 0) ? 65536 : m_per;
            inc  = (tick == 1 && !(bus_wr && a == 4) && m_pph + 1 == peff) ? 1 : 0;
            pitf = (tick == 1 && !(bus_wr && a == 0) && m_pph2 + 1 == qeff) ? 1 : 0;
            wdf  = (tick == 1 && !(bus_wr && a == 32) && m_warm == 1 && m_wd == 1) ? 1 : 0;
            alf  = (inc == 1 && ((m_cnt + 1) % CMOD) == m_alm) ? 1 : 0;
            ev   = pitf | (wdf << 1) | (inc << 2) | (alf << 3);
            if (bus_rd) begin
                case (a)
                    0:  m_rdata = m_per;
                    4:  m_rdata = m_presc;
                    8:  m_rdata = m_st;
                    20: m_rdata = m_mask;
                    24: m_rdata = m_alm;
                    28: m_rdata = m_cnt;
                    default: m_rdata = 0;
                endcase
            end
            if (bus_wr && a == 4) begin
                m_presc = d & 32'hFFFF; m_pph = 0; m_cnt = 0;
            end else if (tick == 1) begin
                m_pph = (inc == 1) ? 0 : m_pph + 1;
                if (inc == 1) m_cnt = (m_cnt + 1) % CMOD;
            end
            if (bus_wr && a == 0) begin
                m_per = d & 32'hFFFF; m_pph2 = 0;
            end else if (tick == 1) m_pph2 = (pitf == 1) ? 0 : m_pph2 + 1;
            if (bus_wr && a == 32) begin
                m_wd = d & 32'hFFFF; m_warm = (m_wd != 0) ? 1 : 0;
            end else if (tick == 1 && m_warm == 1) begin
                m_wd = m_wd - 1;
                if (m_wd == 0) m_warm = 0;
            end
            if (bus_wr && a == 24) m_alm = d & (CMOD - 1);
            if (bus_wr && a == 12) m_mask = m_mask | (d & 15);
            else if (bus_wr && a == 16) m_mask = m_mask & ~(d & 15);
            m_st = ((bus_rd && a == 8) ? 0 : m_st) | ev;
            m3 = m2; m2 = m1; m1 = int'(slow_clk);
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (ready) begin
            checks++;
            if (bus_rdata !== 32'(m_rdata)) begin
                errors++;
                $display("FAIL %s rdata actual=%0h expected=%0h", cur_tag, bus_rdata, m_rdata);
            end
            checks++;
            if (irq !== ((m_st & m_mask) != 0)) begin
                errors++;
                $display("FAIL R10 irq actual=%0b expected=%0b", irq, (m_st & m_mask) != 0);
            end
        end
    end

    // Slow reference clock: 8 bus cycles per period.
    always @(negedge clk) begin
        if (srun) begin
            sc++;
            if (sc == 4) begin sc = 0; slow_clk = ~slow_clk; end
        end
    end

    // Watchdog on the run length.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = 32'(d);
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input string tag, output int v);
        @(negedge clk); cur_tag = tag; bus_rd = 1'b1; bus_addr = 6'(a);
        @(negedge clk); bus_rd = 1'b0; v = int'(bus_rdata);
    endtask

    task automatic chk(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int v;
        idle(4);
        rst_n = 1'b1;
        // Reset state.
        rd(20, "R9", v);  chk(v, 0, "R9 mask reset");
        rd(4, "R2", v);   chk(v, 32'h8000, "R2 prescaler reset");
        rd(8, "R8", v);   chk(v, 0, "R8 status reset");
        rd(28, "R1", v);  chk(v, 0, "R1 counter reset");
        rd(0, "R5", v);   chk(v, 0, "R5 period reset");
        rd(36, "R11", v); chk(v, 0, "R11 unmapped offset");
        srun = 1;
        // Counter on every slow edge.
        wr(4, 1); idle(100);
        rd(28, "R1", v);  chk((v >= 10 && v <= 14) ? 1 : 0, 1, "R1 count after 100 cycles");
        wr(28, 32'h55); rd(28, "R1", v); chk((v < 32'h50) ? 1 : 0, 1, "R1 write ignored");
        rd(8, "R6", v);   chk((v >> 2) & 1, 1, "R6 increment status");
        // Prescaler of three.
        wr(4, 3); idle(120);
        rd(28, "R2", v);  chk((v >= 4 && v <= 6) ? 1 : 0, 1, "R2 divide by three");
        // Mask handling and interrupt.
        wr(12, 0); rd(20, "R9", v); chk(v, 0, "R9 zero enable no effect");
        wr(12, 4); rd(20, "R9", v); chk(v, 4, "R9 enable bit2");
        idle(40); chk(int'(irq), 1, "R10 irq high");
        rd(8, "R10", v);
        wr(16, 0); rd(20, "R9", v); chk(v, 4, "R9 zero disable no effect");
        wr(16, 4); rd(20, "R9", v); chk(v, 0, "R9 disable bit2");
        // Periodic timer.
        wr(0, 5); rd(8, "R5", v); idle(130);
        rd(8, "R5", v);   chk(v & 1, 1, "R5 periodic status");
        rd(0, "R5", v);   chk(v, 5, "R5 period readback");
        // Alarm ahead of the count.
        wr(4, 1); wr(24, 20); rd(8, "R3", v); idle(80);
        rd(8, "R3", v);   chk((v >> 3) & 1, 0, "R3 alarm not yet");
        idle(120);
        rd(8, "R3", v);   chk((v >> 3) & 1, 1, "R3 alarm fired");
        rd(24, "R3", v);  chk(v, 20, "R3 alarm readback");
        // Alarm replacement.
        rd(8, "R4", v); wr(4, 1); wr(24, 30); idle(80); wr(24, 60); idle(280);
        rd(8, "R4", v);   chk((v >> 3) & 1, 0, "R4 old target dropped");
        idle(160);
        rd(8, "R4", v);   chk((v >> 3) & 1, 1, "R4 new target fired");
        // Alarm equal to current count waits a full wrap.
        wr(24, 0); wr(4, 1); rd(8, "R3", v); idle(4000);
        rd(8, "R3", v);   chk((v >> 3) & 1, 0, "R3 equal count no early fire");
        idle(4800);
        rd(8, "R3", v);   chk((v >> 3) & 1, 1, "R3 fired after wrap");
        rd(28, "R1", v);  chk((v < 300) ? 1 : 0, 1, "R1 counter wrapped");
        // Watchdog.
        rd(8, "R7", v); wr(32, 6); idle(20);
        rd(8, "R7", v);   chk((v >> 1) & 1, 0, "R7 not expired");
        idle(60);
        rd(8, "R7", v);   chk((v >> 1) & 1, 1, "R7 expired");
        idle(80);
        rd(8, "R7", v);   chk((v >> 1) & 1, 0, "R7 stopped after expiry");
        wr(32, 3); wr(32, 0); idle(60);
        rd(8, "R7", v);   chk((v >> 1) & 1, 0, "R7 disarmed");
        // Back-to-back status reads that coincide with events.
        wr(12, 15);
        for (int i = 0; i < 40; i++) rd(8, "R8", v);
        idle(10);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule